// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a 24-bit memory address into one of four active-low external chip-select strobes, or into an internal-RAM select. Each chip select owns a window of whole 64 KB pages. The window is set by an 8-bit lower bound and an 8-bit upper bound, which are compared against address bits 23:16, and by an enable bit. A separate 8 KB internal-RAM window sits above all of them in priority. Windows may overlap. Overlaps resolve by fixed priority: RAM first, then chip select 0, 1, 2 and 3.

A small synchronous register port loads the bounds, the enable mask and the RAM window, and reads them back. The decode is purely combinational from the address and a memory-request qualifier, so a bus controller can use the strobes in the same cycle it presents the address. Out of reset, chip select 0 spans the full 16 MB, so a boot fetch reaches external memory before any setup.

Top module: `csdec_top`

## Requirements
- R1: Chip select n matches when it is enabled and lower bound n <= addr[23:16] <= upper bound n. Both bounds are inclusive.
- R2: When a chip select's lower and upper bounds are equal, it matches exactly the one 64 KB page with that number.
- R3: When several enabled windows match, only the lowest-numbered chip select is driven low.
- R4: Register 5 sets the RAM window. Bits [10:0] give the 8 KB block number, which is compared against addr[23:13], and bit 15 enables the window. A RAM hit drives `ramSel` high and keeps every `csN` bit high, even when a chip-select window covers the address.
- R5: After reset, chip select 0 has lower bound 00h, upper bound FFh and is enabled. Chip selects 1 to 3 have both bounds 00h and are disabled. The RAM window is disabled. As a result, `csN` = 4'b1110 for every address while `memReq` is high.
- R6: Register 4 bits [3:0] hold the per-chip-select enables. A disabled chip select never matches, and a lower-priority window that covers the address is still selected in its place.
- R7: While `memReq` is low, `csN` is 4'b1111 and `ramSel` is 0.
- R8: At most one `csN` bit is low in any cycle.
- R9: Register n (n = 0 to 3) holds the lower bound of chip select n in bits [7:0] and its upper bound in bits [15:8]. A write takes effect on the next rising clock edge. `regRdData` returns the register selected by `regAddr`, and addresses 6 and 7 read as zero.
- R10: `csN` and `ramSel` follow a change of `addr` or `memReq` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | input | 1 | High during a valid memory cycle |
| addr | input | 24 | Memory address |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for writes and reads |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for the register selected by `regAddr` |
| csN | output | 4 | Active-low chip selects, bit n for chip select n |
| ramSel | output | 1 | High when the address falls in the internal RAM window |

## Verification
The main table programs two windows that overlap on pages 18h to 1Fh, a single-page window at page 40h, a full-span lowest-priority window, and an enabled RAM block inside the overlap. It then walks addresses at both ends of each window and of the RAM block. Hits at the window edges show whether the bounds are inclusive, and the neighbouring pages show whether the single-page window spills over. The overlap addresses show whether the lowest-numbered select wins, and the RAM-block edges show whether RAM suppresses the chip selects. Directed cases then check the reset mapping at low, middle and top addresses, an idle request, a disabled chip select that must neither match nor block, a disabled RAM window, and the one-edge write latency seen through readback.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W      = 24;
  localparam int PAGE_W      = 8;
  localparam int CS_COUNT    = 4;
  localparam int RAM_BLK_LSB = 13;
  localparam int RAM_BASE_W  = ADDR_W - RAM_BLK_LSB;
  localparam int DATA_W      = 2 * PAGE_W;
  localparam int REG_AW      = $clog2(CS_COUNT + 2);
  localparam int REG_EN      = CS_COUNT;
  localparam int REG_RAM     = CS_COUNT + 1;

  typedef struct packed {
    logic [CS_COUNT-1:0] boundWr;
    logic                enWr;
    logic                ramWr;
    logic [DATA_W-1:0]   wrData;
  } regStrobe_t;
endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output regStrobe_t        strobe
);
  for (genvar i = 0; i < CS_COUNT; i++) begin : g_bwr
    assign strobe.boundWr[i] = regWrEn && (regAddr == REG_AW'(i));
  end
  assign strobe.enWr   = regWrEn && (regAddr == REG_AW'(REG_EN));
  assign strobe.ramWr  = regWrEn && (regAddr == REG_AW'(REG_RAM));
  assign strobe.wrData = regWrData;
endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              memReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic [CS_COUNT-1:0] csN,
  output logic              ramSel
);
  localparam int PAD_W = DATA_W - RAM_BASE_W - 1;

  logic [PAGE_W-1:0]     loBound [CS_COUNT];
  logic [PAGE_W-1:0]     hiBound [CS_COUNT];
  logic [CS_COUNT-1:0]   csEn;
  logic [RAM_BASE_W-1:0] ramBase;
  logic                  ramEn;
  logic [PAGE_W-1:0]     page;
  logic [CS_COUNT-1:0]   winHit;
  logic [CS_COUNT-1:0]   grant;
  logic                  ramHit;

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_bound
    localparam logic [PAGE_W-1:0] HI_RST = (i == 0) ? '1 : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loBound[i] <= '0;
        hiBound[i] <= HI_RST;
      end else if (strobe.boundWr[i]) begin
        loBound[i] <= strobe.wrData[PAGE_W-1:0];
        hiBound[i] <= strobe.wrData[DATA_W-1:PAGE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csEn    <= CS_COUNT'(1);
      ramBase <= '0;
      ramEn   <= 1'b0;
    end else begin
      if (strobe.enWr)
        csEn <= strobe.wrData[CS_COUNT-1:0];
      if (strobe.ramWr) begin
        ramBase <= strobe.wrData[RAM_BASE_W-1:0];
        ramEn   <= strobe.wrData[DATA_W-1];
      end
    end
  end

  assign page   = addr[ADDR_W-1 -: PAGE_W];
  assign ramHit = memReq && ramEn && (addr[ADDR_W-1:RAM_BLK_LSB] == ramBase);

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cmp
    assign winHit[i] = csEn[i] && (page >= loBound[i]) && (page <= hiBound[i]);
  end

  always_comb begin
    logic taken;
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < CS_COUNT; i++) begin
      if (winHit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign csN    = (memReq && !ramHit) ? ~grant : '1;
  assign ramSel = ramHit;

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < CS_COUNT; i++) begin
      if (regAddr == REG_AW'(i))
        regRdData = {hiBound[i], loBound[i]};
    end
    if (regAddr == REG_AW'(REG_EN))
      regRdData = DATA_W'(csEn);
    if (regAddr == REG_AW'(REG_RAM))
      regRdData = {ramEn, {PAD_W{1'b0}}, ramBase};
  end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                memReq,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [CS_COUNT-1:0] csN,
  output logic                ramSel
);
  regStrobe_t strobe;

  csdec_ctrl ctrl_i (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  csdec_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memReq   (memReq),
    .addr     (addr),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .csN      (csN),
    .ramSel   (ramSel)
  );
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker
  import csdec_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                memReq,
  input logic                regWrEn,
  input logic [CS_COUNT-1:0] csN,
  input logic                ramSel
);
  logic untouched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        untouched <= 1'b1;
    else if (regWrEn) untouched <= 1'b0;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (&csN && !ramSel)); // R7
  AST_RAM_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> &csN); // R4
  AST_RESET_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (untouched && memReq) |-> (csN == 4'b1110 && !ramSel)); // R5
endmodule

bind csdec_top csdec_checker chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .memReq (memReq),
  .regWrEn(regWrEn),
  .csN    (csN),
  .ramSel (ramSel)
);

// File: tb/csdec_top_tb_top.sv
`timescale 1ns/1ps
module csdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq = 1'b0;
  logic [23:0] addr = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0]  csN;
  logic        ramSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csdec_top dut_i (
    .clk(clk), .rstN(rstN), .memReq(memReq), .addr(addr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .csN(csN), .ramSel(ramSel)
  );

  // {addr, ramSel, csN} with the table configuration loaded
  localparam logic [28:0] VEC [16] = '{
    {24'h000000, 1'b0, 4'b0111},  // R1 below CS0 -> CS3
    {24'h100000, 1'b0, 4'b1110},  // R1 CS0 low edge
    {24'h1FFFFF, 1'b0, 4'b1110},  // R1 CS0 high edge
    {24'h17FFFF, 1'b0, 4'b1110},  // R4 just below RAM block
    {24'h180000, 1'b1, 4'b1111},  // R4 RAM start
    {24'h181FFF, 1'b1, 4'b1111},  // R4 RAM end
    {24'h182000, 1'b0, 4'b1110},  // R3 overlap, CS0 beats CS1
    {24'h200000, 1'b0, 4'b1101},  // R1 CS1 after overlap
    {24'h2FFFFF, 1'b0, 4'b1101},  // R1 CS1 high edge
    {24'h300000, 1'b0, 4'b0111},  // R3 CS3 fills gap
    {24'h3FFFFF, 1'b0, 4'b0111},  // R2 page before single page
    {24'h400000, 1'b0, 4'b1011},  // R2 single page start
    {24'h40FFFF, 1'b0, 4'b1011},  // R2 single page end
    {24'h410000, 1'b0, 4'b0111},  // R2 page after single page
    {24'h800000, 1'b0, 4'b0111},  // R3 CS3 middle
    {24'hFFFFFF, 1'b0, 4'b0111}   // R3 CS3 top
  };

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 check(req, {1'b0, regRdData}, {1'b0, exp});
  endtask

  task automatic probe(input string req, input logic [23:0] a, input logic [4:0] exp);
    @(negedge clk);
    memReq = 1'b1; addr = a;
    #1 check(req, {12'h0, ramSel, csN}, {12'h0, exp});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R5 reset mapping and register contents
    probe("R5", 24'h000000, 5'b0_1110);
    probe("R5", 24'h8ABCDE, 5'b0_1110);
    probe("R5", 24'hFFFFFF, 5'b0_1110);
    regRead("R5", 3'd0, 16'hFF00);
    regRead("R5", 3'd1, 16'h0000);
    regRead("R5", 3'd3, 16'h0000);
    regRead("R5", 3'd4, 16'h0001);
    regRead("R5", 3'd5, 16'h0000);

    // R7 idle request
    @(negedge clk); memReq = 1'b0; addr = 24'h123456;
    #1 check("R7", {12'h0, ramSel, csN}, {12'h0, 5'b0_1111});

    // R9 write latency: value visible only after the edge
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 16'h1F10;
    #1 check("R9", {1'b0, regRdData}, {1'b0, 16'hFF00});
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R9", {1'b0, regRdData}, {1'b0, 16'h1F10});
    regWrite(3'd1, 16'h2F18);
    regWrite(3'd2, 16'h4040);
    regWrite(3'd3, 16'hFF00);
    regWrite(3'd4, 16'h000F);
    regWrite(3'd5, 16'h80C0);
    regRead("R9", 3'd1, 16'h2F18);
    regRead("R9", 3'd5, 16'h80C0);
    regRead("R9", 3'd6, 16'h0000);
    regRead("R9", 3'd7, 16'h0000);

    // main table: R1 R2 R3 R4
    for (int i = 0; i < 16; i++)
      probe("R1/R2/R3/R4 table", VEC[i][28:5], VEC[i][4:0]);

    // R10 same-cycle response to an address change
    @(negedge clk); addr = 24'h400000;
    #0.5 check("R10", {12'h0, ramSel, csN}, {12'h0, 5'b0_1011});
    addr = 24'h180000;
    #0.5 check("R10", {12'h0, ramSel, csN}, {12'h0, 5'b1_1111});

    // R6 disabled CS0 neither matches nor blocks
    regWrite(3'd4, 16'h000E);
    probe("R6", 24'h100000, 5'b0_0111);
    probe("R6", 24'h1A0000, 5'b0_1101);
    regWrite(3'd4, 16'h0007);
    probe("R6", 24'h900000, 5'b0_1111);

    // R4 RAM window disabled
    regWrite(3'd4, 16'h000F);
    regWrite(3'd5, 16'h00C0);
    probe("R4", 24'h180000, 5'b0_1110);

    @(negedge clk); memReq = 1'b0;
    finishRun();
  end
endmodule